// File: doc/BRIEF.md
# Level-Priority Vectored Interrupt Controller

This block collects thirteen interrupt request lines, numbered 1 to 13, and presents a single request to the processor as a 3-bit level and an 8-bit vector. Each source has a pending bit that follows its line. A mask bit blocks the source. An 8-bit control byte per source holds a 5-bit priority, with the level in the upper three bits of that priority, and a flag that picks how the vector is formed. Among the pending, unmasked sources, the one with the strictly greatest priority wins. A winner whose priority sits below the first level presents nothing.

When the winner's flag is set, the vector is autovectored as 24 plus the level. When the flag is clear, a stored vector is used. The watchdog source and the two serial-port sources each have their own programmable vector register. Every other source falls back to a fixed vector. Software reaches the control bytes, the mask and the three vector registers through a simple synchronous register port, and can read the pending bits back.

The level and vector outputs are registered. A change in pending bits, in the mask or in a control byte shows at the outputs on the following clock.

Top module: `lvl_vec_intc`

## Requirements
- R1: The pending bit of source n (1 to 13) takes the value of `src_in[n]` at each rising clock edge. It reads back at address 0x11 as bit n, and bit 0 reads 0. Writes to address 0x11 change nothing.
- R2: A mask bit n of 1 removes source n from selection. When no pending source is unmasked, the level and vector outputs are 0.
- R3: The priority of a source is bits 4:0 of its control byte. The source with the strictly greatest priority wins, so on equal priority the lower-numbered source wins.
- R4: When the winning priority is below 4, both the level and the vector are 0.
- R5: The level output equals bits 4:2 of the winner's control byte.
- R6: When bit 7 of the winner's control byte is 1, the vector is 24 plus the level.
- R7: When bit 7 is 0, the vector comes from a register chosen by the winning source. Source 8 uses the watchdog vector (address 0x12), source 12 uses serial vector A (0x13), and source 13 uses serial vector B (0x14). Any other source gets 0x0F.
- R8: Synchronous active-high reset sets the following values. Control bytes of sources 1 to 7 become 4×n, and source 8 becomes 0x1C. Sources 9 to 11 become 0x80, and sources 12 and 13 become 0x00. The mask becomes 0x3FFE, the watchdog vector 0x0F, both serial vectors 0x00, and the level and vector outputs 0.
- R9: The level and vector change exactly one clock after the state change that causes them: a register write or a pending-bit update.
- R10: Address n (1 to 13) holds control byte n (bits 15:8 read 0). Address 0x10 holds the mask in bits 13:0, and addresses 0x12 to 0x14 hold 8-bit vectors. Read data appears one clock after the address. Unmapped addresses read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | 14 | Request lines; bit n is source n, bit 0 unused |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, one clock after address |
| irq_level | output | 3 | Presented interrupt level, 0 for none |
| irq_vector | output | 8 | Presented interrupt vector, 0 for none |

## Verification
All request lines are raised at once while masked, and then unmasked. This separates the effect of the mask from that of priority. Two sources at equal priority are given distinct vectors, so the tie-break becomes visible on the vector output. A single source is then walked through an autovector control byte, a stored-vector byte and a sub-threshold priority. These cases separate the three vector paths from the suppression rule. A mask write is sampled on both sides of its update edge to pin the one-clock latency, and a behavioural model compares level, vector and read data on every clock throughout.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int CTRL_W = 8;
  localparam int VEC_W  = 8;
  localparam int LVL_W  = 3;
  localparam int PRIO_W = 5;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 16;

  localparam logic [ADDR_W-1:0] A_MASK   = 5'h10;
  localparam logic [ADDR_W-1:0] A_PEND   = 5'h11;
  localparam logic [ADDR_W-1:0] A_WDVEC  = 5'h12;
  localparam logic [ADDR_W-1:0] A_SERA   = 5'h13;
  localparam logic [ADDR_W-1:0] A_SERB   = 5'h14;

  localparam logic [VEC_W-1:0] FALLBACK_VEC = 8'h0F;
  localparam logic [VEC_W-1:0] AUTO_BASE    = 8'd24;

  function automatic logic [CTRL_W-1:0] ctrl_reset(input int idx);
    if (idx >= 1 && idx <= 7) return CTRL_W'(4 * idx);
    else if (idx == 8)        return 8'h1C;
    else if (idx >= 9 && idx <= 11) return 8'h80;
    else                      return 8'h00;
  endfunction
endpackage

// File: rtl/intc_pending.sv
module intc_pending #(
  parameter int NUM_SRC = 13
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC:1]   src_in,
  output logic [NUM_SRC:1]   pend_q
);
  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= src_in;
  end
endmodule

// File: rtl/intc_regfile.sv
module intc_regfile
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 13
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          we,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             wdata,
  input  logic [NUM_SRC:1]              pend,
  output logic [NUM_SRC:1][CTRL_W-1:0]  ctrl_q,
  output logic [NUM_SRC:0]              mask_q,
  output logic [VEC_W-1:0]              wdvec_q,
  output logic [VEC_W-1:0]              sera_q,
  output logic [VEC_W-1:0]              serb_q,
  output logic [DATA_W-1:0]             rdata
);
  localparam logic [NUM_SRC:0] MASK_RST = {{NUM_SRC{1'b1}}, 1'b0};

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 1; i <= NUM_SRC; i++) ctrl_q[i] <= ctrl_reset(i);
      mask_q  <= MASK_RST;
      wdvec_q <= FALLBACK_VEC;
      sera_q  <= '0;
      serb_q  <= '0;
    end else if (we) begin
      for (int i = 1; i <= NUM_SRC; i++)
        if (addr == ADDR_W'(i)) ctrl_q[i] <= wdata[CTRL_W-1:0];
      if (addr == A_MASK)  mask_q  <= wdata[NUM_SRC:0];
      if (addr == A_WDVEC) wdvec_q <= wdata[VEC_W-1:0];
      if (addr == A_SERA)  sera_q  <= wdata[VEC_W-1:0];
      if (addr == A_SERB)  serb_q  <= wdata[VEC_W-1:0];
    end
  end

  logic [DATA_W-1:0] rd_next;
  always_comb begin
    rd_next = '0;
    for (int i = 1; i <= NUM_SRC; i++)
      if (addr == ADDR_W'(i)) rd_next = DATA_W'(ctrl_q[i]);
    case (addr)
      A_MASK:  rd_next = DATA_W'(mask_q);
      A_PEND:  rd_next = DATA_W'({pend, 1'b0});
      A_WDVEC: rd_next = DATA_W'(wdvec_q);
      A_SERA:  rd_next = DATA_W'(sera_q);
      A_SERB:  rd_next = DATA_W'(serb_q);
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end
endmodule

// File: rtl/intc_select.sv
module intc_select
  import intc_pkg::*;
#(
  parameter int NUM_SRC  = 13,
  parameter int PRIO_MIN = 4,
  localparam int IDX_W   = $clog2(NUM_SRC + 1)
) (
  input  logic [NUM_SRC:1]              pend,
  input  logic [NUM_SRC:0]              mask,
  input  logic [NUM_SRC:1][CTRL_W-1:0]  ctrl,
  output logic                          win_valid,
  output logic [IDX_W-1:0]              win_idx,
  output logic [CTRL_W-1:0]             win_ctrl
);
  logic [NUM_SRC:1]  active;
  logic [PRIO_W-1:0] best;

  assign active = pend & ~mask[NUM_SRC:1];

  always_comb begin
    best     = '0;
    win_idx  = '0;
    win_ctrl = '0;
    for (int i = 1; i <= NUM_SRC; i++) begin
      if (active[i] && (ctrl[i][PRIO_W-1:0] > best)) begin
        best     = ctrl[i][PRIO_W-1:0];
        win_idx  = IDX_W'(i);
        win_ctrl = ctrl[i];
      end
    end
    win_valid = (best >= PRIO_W'(PRIO_MIN));
  end
endmodule

// File: rtl/intc_output.sv
module intc_output
  import intc_pkg::*;
#(
  parameter int NUM_SRC  = 13,
  parameter int WDOG_SRC = 8,
  parameter int SERA_SRC = 12,
  parameter int SERB_SRC = 13,
  localparam int IDX_W   = $clog2(NUM_SRC + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               win_valid,
  input  logic [IDX_W-1:0]   win_idx,
  input  logic [CTRL_W-1:0]  win_ctrl,
  input  logic [VEC_W-1:0]   wdvec,
  input  logic [VEC_W-1:0]   sera,
  input  logic [VEC_W-1:0]   serb,
  output logic [LVL_W-1:0]   irq_level,
  output logic [VEC_W-1:0]   irq_vector
);
  logic [LVL_W-1:0] lvl_next;
  logic [VEC_W-1:0] vec_next;

  always_comb begin
    lvl_next = win_ctrl[PRIO_W-1:PRIO_W-LVL_W];
    if (win_ctrl[CTRL_W-1])            vec_next = AUTO_BASE + VEC_W'(lvl_next);
    else if (win_idx == IDX_W'(WDOG_SRC)) vec_next = wdvec;
    else if (win_idx == IDX_W'(SERA_SRC)) vec_next = sera;
    else if (win_idx == IDX_W'(SERB_SRC)) vec_next = serb;
    else                               vec_next = FALLBACK_VEC;
    if (!win_valid) begin
      lvl_next = '0;
      vec_next = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_level  <= '0;
      irq_vector <= '0;
    end else begin
      irq_level  <= lvl_next;
      irq_vector <= vec_next;
    end
  end
endmodule

// File: rtl/lvl_vec_intc.sv
module lvl_vec_intc
  import intc_pkg::*;
#(
  parameter int NUM_SRC  = 13,
  parameter int PRIO_MIN = 4,
  parameter int WDOG_SRC = 8,
  parameter int SERA_SRC = 12,
  parameter int SERB_SRC = 13
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_SRC:0]    src_in,
  input  logic                reg_we,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic [LVL_W-1:0]    irq_level,
  output logic [VEC_W-1:0]    irq_vector
);
  localparam int IDX_W = $clog2(NUM_SRC + 1);

  logic [NUM_SRC:1]             pend_q;
  logic [NUM_SRC:1][CTRL_W-1:0] ctrl_q;
  logic [NUM_SRC:0]             mask_q;
  logic [VEC_W-1:0]             wdvec_q, sera_q, serb_q;
  logic                         win_valid;
  logic [IDX_W-1:0]             win_idx;
  logic [CTRL_W-1:0]            win_ctrl;

  intc_pending #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk(clk), .rst(rst), .src_in(src_in[NUM_SRC:1]), .pend_q(pend_q)
  );

  intc_regfile #(.NUM_SRC(NUM_SRC)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .pend(pend_q), .ctrl_q(ctrl_q), .mask_q(mask_q), .wdvec_q(wdvec_q),
    .sera_q(sera_q), .serb_q(serb_q), .rdata(reg_rdata)
  );

  intc_select #(.NUM_SRC(NUM_SRC), .PRIO_MIN(PRIO_MIN)) u_sel (
    .pend(pend_q), .mask(mask_q), .ctrl(ctrl_q),
    .win_valid(win_valid), .win_idx(win_idx), .win_ctrl(win_ctrl)
  );

  intc_output #(.NUM_SRC(NUM_SRC), .WDOG_SRC(WDOG_SRC),
                .SERA_SRC(SERA_SRC), .SERB_SRC(SERB_SRC)) u_out (
    .clk(clk), .rst(rst), .win_valid(win_valid), .win_idx(win_idx),
    .win_ctrl(win_ctrl), .wdvec(wdvec_q), .sera(sera_q), .serb(serb_q),
    .irq_level(irq_level), .irq_vector(irq_vector)
  );
endmodule

// File: rtl/intc_chk.sv
module intc_chk #(
  parameter int NUM_SRC = 13
) (
  input logic             clk,
  input logic             rst,
  input logic [NUM_SRC:0] src_in,
  input logic             reg_we,
  input logic [NUM_SRC:1] pend,
  input logic [NUM_SRC:0] mask,
  input logic [2:0]       irq_level,
  input logic [7:0]       irq_vector
);
  // R1: pending register mirrors the line one clock later
  assert_pend_follow_R1: assert property (@(posedge clk) disable iff (rst)
    pend == $past(src_in[NUM_SRC:1]));

  // R2: nothing unmasked and pending means no request
  assert_masked_idle_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(pend & ~mask[NUM_SRC:1]) == '0) |-> (irq_level == 3'd0));

  // R4: no level means no vector
  assert_zero_pair_R4: assert property (@(posedge clk) disable iff (rst)
    (irq_level == 3'd0) |-> (irq_vector == 8'd0));

  // R8: outputs are idle right after reset
  assert_reset_idle_R8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (irq_level == 3'd0 && irq_vector == 8'd0));

  // R9: with state unchanged, outputs hold
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst, 2) && !$past(reg_we, 2) && ($past(pend) == $past(pend, 2)))
    |-> ($stable(irq_level) && $stable(irq_vector)));
endmodule

bind lvl_vec_intc intc_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk(clk), .rst(rst), .src_in(src_in), .reg_we(reg_we), .pend(pend_q),
  .mask(mask_q), .irq_level(irq_level), .irq_vector(irq_vector)
);

// File: tb/lvl_vec_intc_tb.sv
module lvl_vec_intc_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [13:0] src_in = '0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [2:0]  irq_level;
  logic [7:0]  irq_vector;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lvl_vec_intc u_dut (
    .clk(clk), .rst(rst), .src_in(src_in), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_level(irq_level), .irq_vector(irq_vector)
  );

  // behavioural reference model
  int m_ctrl[14];
  int m_mask, m_pend, m_wd, m_sa, m_sb;
  int e_lvl, e_vec, e_rd;
  bit live = 0;

  function automatic int m_read(int a);
    if (a >= 1 && a <= 13) return m_ctrl[a];
    case (a)
      16: return m_mask;
      17: return m_pend;
      18: return m_wd;
      19: return m_sa;
      20: return m_sb;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 1; i <= 13; i++)
        m_ctrl[i] = (i <= 7) ? 4 * i : (i == 8) ? 'h1C : (i <= 11) ? 'h80 : 0;
      m_mask = 'h3FFE; m_pend = 0; m_wd = 'h0F; m_sa = 0; m_sb = 0;
      e_lvl = 0; e_vec = 0; e_rd = 0;
      live = 1;
    end else begin
      int best, win;
      best = 0; win = 0;
      for (int i = 1; i <= 13; i++)
        if (((m_pend >> i) & 1) && !((m_mask >> i) & 1) && (m_ctrl[i] % 32) > best) begin
          best = m_ctrl[i] % 32; win = i;
        end
      if (best < 4) begin e_lvl = 0; e_vec = 0; end
      else begin
        e_lvl = best / 4;
        if (m_ctrl[win] >= 128) e_vec = 24 + e_lvl;
        else if (win == 8)  e_vec = m_wd;
        else if (win == 12) e_vec = m_sa;
        else if (win == 13) e_vec = m_sb;
        else e_vec = 'h0F;
      end
      e_rd = m_read(reg_addr);
      if (reg_we) begin
        if (reg_addr >= 1 && reg_addr <= 13) m_ctrl[reg_addr] = reg_wdata & 'hFF;
        else if (reg_addr == 16) m_mask = reg_wdata & 'h3FFF;
        else if (reg_addr == 18) m_wd = reg_wdata & 'hFF;
        else if (reg_addr == 19) m_sa = reg_wdata & 'hFF;
        else if (reg_addr == 20) m_sb = reg_wdata & 'hFF;
      end
      m_pend = src_in & 'h3FFE;
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (live && !done) begin
      check("R5 model level", irq_level, e_lvl);
      check("R6/R7 model vector", irq_vector, e_vec);
      check("R10 model rdata", reg_rdata, e_rd);
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 5'(a); reg_wdata = 16'(d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(int a, output int v);
    @(negedge clk);
    reg_addr = 5'(a);
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    int v;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R8 reset level", irq_level, 0);
    check("R8 reset vector", irq_vector, 0);
    rd(1, v);  check("R8 ctrl1 reset", v, 'h04);
    rd(7, v);  check("R8 ctrl7 reset", v, 'h1C);
    rd(8, v);  check("R8 ctrl8 reset", v, 'h1C);
    rd(10, v); check("R8 ctrl10 reset", v, 'h80);
    rd(13, v); check("R8 ctrl13 reset", v, 'h00);
    rd(16, v); check("R8 mask reset", v, 'h3FFE);
    rd(18, v); check("R8 wdog vec reset", v, 'h0F);

    // all lines up while masked
    src_in = 14'h3FFE;
    settle();
    check("R2 all masked level", irq_level, 0);
    check("R2 all masked vector", irq_vector, 0);
    rd(17, v); check("R1 pending readback", v, 'h3FFE);

    // tie between 7 and 8 at priority 0x1C
    wr(18, 'h40);
    wr(16, 0);
    settle();
    check("R5 tie level", irq_level, 7);
    check("R3 tie lower source wins", irq_vector, 'h0F);
    src_in[7] = 1'b0;
    settle();
    check("R7 watchdog vector", irq_vector, 'h40);

    // single source 1
    src_in = 14'h0002;
    settle();
    check("R5 source1 level", irq_level, 1);
    check("R7 fallback vector", irq_vector, 'h0F);
    wr(1, 'h84);
    settle();
    check("R6 autovector", irq_vector, 25);
    wr(1, 'h03);
    settle();
    check("R4 low prio level", irq_level, 0);
    check("R4 low prio vector", irq_vector, 0);
    wr(1, 'h84);

    // serial sources
    wr(12, 'h14); wr(19, 'h55);
    src_in = 14'h1002;
    settle();
    check("R5 serial A level", irq_level, 5);
    check("R7 serial A vector", irq_vector, 'h55);
    wr(13, 'h18); wr(20, 'h66);
    src_in = 14'h3002;
    settle();
    check("R7 serial B vector", irq_vector, 'h66);
    check("R3 higher prio wins", irq_level, 6);

    // one-clock latency of a mask write
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 5'd16; reg_wdata = 16'h3FFE;
    @(negedge clk);
    reg_we = 1'b0;
    check("R9 before update", irq_level, 6);
    @(negedge clk);
    check("R9 after update", irq_level, 0);

    // pending register is read-only
    wr(17, 0);
    rd(17, v); check("R1 pending write ignored", v, 'h3002);

    // register map edges
    rd(31, v); check("R10 unmapped reads 0", v, 0);
    wr(2, 'hFFFF);
    rd(2, v);  check("R10 ctrl upper bits", v, 'hFF);
    rd(12, v); check("R10 ctrl12 readback", v, 'h14);

    settle();
    finish_run();
  end
endmodule